// File: doc/BRIEF.md
# Read-Armed Output Offset Flag Bank

This block keeps one offset flag per amplifier output channel. The flags are armed by the host itself: each read of the offset status returns the current flags and then sets every flag again. Between two reads, an external window comparator reports for each channel whether the output currently lies inside the small voltage window around zero. Any such report clears that channel's flag. The flag then stays clear until the next read arms it again.

A flag that is still set at a read therefore shows that the channel's output never came near zero during the whole interval since the previous read. That points to a DC offset, or to a signal whose period is longer than the read interval. The host chooses the read interval. The block only records what happened between reads.

The flags exist only while the register-controlled operating mode is active. While that mode is off, the flags are held clear, and they are not wired to any interrupt or pin indication.

Top module: `offset_stuck_latch`

## Requirements
- R1: After reset every channel flag is 0 and the returned status word `rd_status` is 0.
- R2: At the clock edge where `rd_pulse` is high, `rd_status` loads the flag values that stood before that edge. That is, it loads the state before the read re-arms the flags. `rd_status` holds its value between reads. Bit i of `rd_status` belongs to channel i.
- R3: With `reg_mode_en` high, a read sets the flag of every channel, so a second read with no window activity in between returns all ones.
- R4: A window report on a channel clears that channel's flag. The flag stays 0 after the window input falls again, until the next read sets it.
- R5: If a read and a synchronized window report act on the same channel in the same cycle, the read wins and the flag is set. The flag clears one cycle later if the report persists.
- R6: Each `in_window` bit passes through a synchronizer of SYNC_STAGES flops (2 by default). An input that goes high just before edge k clears the flag at edge k+2. A read at edge k+2 still returns 1 for that channel, and a read at edge k+3 returns 0.
- R7: While `reg_mode_en` is low, all flags are held at 0 and reads do not set them. A flag armed before the mode was switched off reads back 0 after the mode returns.
- R8: Channels act independently: for every combination of channels that saw the window during an interval, the next read returns 0 on exactly those channels and 1 on all others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_mode_en | input | 1 | Register-controlled mode active; flags are held clear when low |
| rd_pulse | input | 1 | One-cycle strobe marking a host read of the offset status |
| in_window | input | NUM_CH | Per-channel window comparator output (asynchronous), high when the output is inside the window |
| rd_status | output | NUM_CH | Flag values captured by the most recent read |

## Verification
The bench builds the block with its defaults, NUM_CH = 4 and SYNC_STAGES = 2. Four channels keep an exhaustive sweep practical: all 16 combinations of window-touching channels are run, each through a full read interval. The two-flop synchronizer gives a short, fixed delay, so reads can be placed exactly on the edge before the clear and on the edge after it. The bench also places a read in the same cycle as a held window report and covers the mode-off interval.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_ARM   = 2'd1,
    ACT_CLEAR = 2'd2,
    ACT_OFF   = 2'd3
  } ofs_action_e;
endpackage

// File: rtl/ofs_window_sync.sv
module ofs_window_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = async_in;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign sync_out = stage_q[LAST];

  generate
    if (STAGES > 1) begin : g_chk
      AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        stage_q[1] == $past(stage_q[0])); // R6
    end
  endgenerate
endmodule

// File: rtl/ofs_chan_latch.sv
module ofs_chan_latch
  import ofs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_en,
  input  logic rd_pulse,
  input  logic win_sync,
  output logic flag_o
);
  ofs_action_e act;
  logic        flag_q;
  logic        flag_d;
  logic        flag_en;

  always_comb begin
    if (!mode_en)      act = ACT_OFF;
    else if (rd_pulse) act = ACT_ARM;
    else if (win_sync) act = ACT_CLEAR;
    else               act = ACT_HOLD;
  end

  always_comb begin
    flag_en = 1'b1;
    flag_d  = flag_q;
    unique case (act)
      ACT_ARM:   flag_d = 1'b1;
      ACT_CLEAR: flag_d = 1'b0;
      ACT_OFF:   flag_d = 1'b0;
      default:   flag_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  AST_READ_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && rd_pulse) |=> flag_o); // R3
  AST_READ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && rd_pulse && win_sync) |=> flag_o); // R5
  AST_WINDOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (win_sync && !rd_pulse) |=> !flag_o); // R4
  AST_SET_ONLY_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(rd_pulse && mode_en)); // R4
  AST_MODE_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> !flag_o); // R7
endmodule

// File: rtl/offset_stuck_latch.sv
module offset_stuck_latch #(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_mode_en,
  input  logic              rd_pulse,
  input  logic [NUM_CH-1:0] in_window,
  output logic [NUM_CH-1:0] rd_status
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_q;
  logic                  rst_int_n;
  logic [NUM_CH-1:0]     win_s;
  logic [NUM_CH-1:0]     flags;
  logic [NUM_CH-1:0]     status_q;
  logic [NUM_CH-1:0]     status_d;
  logic                  status_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= '0;
    end else begin
      rst_q <= {rst_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_q[RST_STAGES-1];

  ofs_window_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in (in_window),
    .sync_out (win_s)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ofs_chan_latch u_lat (
        .clk      (clk),
        .rst_n    (rst_int_n),
        .mode_en  (reg_mode_en),
        .rd_pulse (rd_pulse),
        .win_sync (win_s[c]),
        .flag_o   (flags[c])
      );
    end
  endgenerate

  always_comb begin
    status_en = rd_pulse;
    status_d  = flags;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      status_q <= '0;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end

  assign rd_status = status_q;

  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_pulse |=> $stable(rd_status)); // R2
  AST_STATUS_PRE_ARM: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_pulse |=> (rd_status == $past(flags))); // R2
  AST_OFF_ALL_CLEAR: assert property (@(posedge clk) disable iff (!rst_int_n)
    !reg_mode_en |=> (flags == '0)); // R7
endmodule

// File: tb/offset_stuck_latch_test.sv
module offset_stuck_latch_test;
  localparam int  NCH = 4;
  localparam time TCLK = 10ns;

  logic           clk;
  logic           rst_n;
  logic           reg_mode_en;
  logic           rd_pulse;
  logic [NCH-1:0] in_window;
  logic [NCH-1:0] rd_status;

  int  checks;
  int  failures;
  bit  done;

  offset_stuck_latch #(.NUM_CH(NCH), .SYNC_STAGES(2)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_mode_en (reg_mode_en),
    .rd_pulse    (rd_pulse),
    .in_window   (in_window),
    .rd_status   (rd_status)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  task automatic check(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Called at a negedge; the read takes effect at the next posedge, result sampled at the following negedge.
  task automatic do_read();
    rd_pulse = 1'b1;
    @(negedge clk);
    rd_pulse = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; reg_mode_en = 1'b1; rd_pulse = 1'b0; in_window = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    check("R1 reset status", rd_status, '0);
    do_read();
    check("R2 first read returns pre-arm zero", rd_status, '0);
    do_read();
    check("R3 read re-arms all", rd_status, '1);

    // R8/R4 sweep over every channel combination
    for (int m = 0; m < (1 << NCH); m++) begin
      in_window = NCH'(m);
      idle(1);
      in_window = '0;
      idle(5);
      do_read();
      check("R8 R4 sweep", rd_status, ~NCH'(m));
      do_read();
      check("R3 re-arm after sweep", rd_status, '1);
    end

    // R6 latency: window high before edge k, read at k+2 then at k+3 (fresh trials)
    for (int d = 2; d <= 3; d++) begin
      do_read();
      in_window = 4'b0001;
      repeat (d) @(posedge clk);
      @(negedge clk);
      do_read();
      check(d == 2 ? "R6 read before clear" : "R6 read after clear",
            rd_status, d == 2 ? 4'b1111 : 4'b1110);
      in_window = '0;
      idle(4);
    end

    // R5 read and window in the same cycle
    in_window = 4'b0100;
    idle(4);
    do_read();
    do_read();
    check("R5 read wins collision", rd_status, 4'b1111);
    idle(2);
    do_read();
    check("R5 clears after collision", rd_status, 4'b1011);
    in_window = '0;
    idle(4);

    // R7 mode off
    do_read();
    reg_mode_en = 1'b0;
    idle(1);
    do_read();
    check("R7 flags cleared while off", rd_status, '0);
    do_read();
    check("R7 read does not arm while off", rd_status, '0);
    reg_mode_en = 1'b1;
    idle(1);
    do_read();
    check("R7 stays clear after mode returns", rd_status, '0);
    do_read();
    check("R3 arm after mode returns", rd_status, '1);

    // R2 status holds between reads
    in_window = 4'b1010;
    idle(6);
    check("R2 status holds without read", rd_status, '1);
    in_window = '0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule